// File: doc/BRIEF.md
# Prescaled Seconds Timer with Alarm

A free-running timer for a domain that stays powered while the rest of the chip sleeps. A 16-bit divide value splits the slow input clock so that a 32-bit up-counter advances once per divide period, normally once a second. Software cannot load the counter. It can only send it back to zero, and that also restarts the divider phase.

Four word registers sit behind a simple synchronous register port:

- a control word holding the divide value, two interrupt enables and a restart command;
- an alarm compare value;
- the read-only count;
- an event word that clears when it is read.

Two events are recorded: every counter advance, and the advance on which the count becomes equal to the alarm value. Each event is gated by its own enable and drives one level interrupt. The all-ones alarm value is the reset value and means that no alarm is set.

Top module: `rt_sec_timer`

## Requirements
- R1: After reset the control word reads 0, the alarm word reads 0xFFFFFFFF, the count reads 0, the event word reads 0 and the interrupt is low.
- R2: The byte offsets are: control at 0x0, alarm at 0x4, count at 0x8, events at 0xC. Control bits 15:0 hold the divide value, bit 16 enables the alarm interrupt and bit 17 enables the advance interrupt. Control and alarm read back what was written.
- R3: With divide value N > 0, the count advances by one every N clock cycles. The first advance comes N cycles after a restart.
- R4: With divide value 0 the count holds its value.
- R5: A control write with bit 18 set clears the count and the divider phase on that edge. Bit 18 always reads back 0.
- R6: Writes to the count and event offsets change nothing.
- R7: Event bit 1 is set on every counter advance.
- R8: Event bit 0 is set on the advance where the count becomes equal to the alarm value.
- R9: Reading the event word returns its current bits and clears them on the same edge.
- R10: If an event occurs on the same edge as an event-word read, that event's bit stays set.
- R11: The interrupt is high exactly when an event bit and its enable (bit 0 with control bit 16, bit 1 with control bit 17) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock that both the divider and the register port run on |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Register access strobe, one access per cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of the access |
| irq | output | 1 | Level interrupt |

## Verification
An event-word read and a new event can fall on the same edge, and so can a clear-on-read and a counter advance. The bench sets the divide value to 1 so that an advance lands on every edge, then reads the event word on back-to-back cycles. The second read must still show the advance bit, because the advance that coincided with the first read keeps it set. The alarm bit, with no new match, must come back cleared.

// File: rtl/rt_sec_timer.sv
module rt_sec_timer #(
  parameter int PRESC_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        wr,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam int DW      = 32;
  localparam int EN_ALM  = PRESC_W;
  localparam int EN_INC  = PRESC_W + 1;
  localparam int RST_BIT = PRESC_W + 2;

  logic [PRESC_W-1:0] presc_q, div_q;
  logic [1:0]         en_q, sts_q;
  logic [DW-1:0]      alarm_q, count_q, count_inc;
  logic               wr_ctl, wr_alm, rd_sts, restart, tick, hit;
  logic               unused_bits;

  assign unused_bits = ^{wdata[DW-1:RST_BIT+1], addr[1:0]};

  assign wr_ctl  = req && wr  && addr[3:2] == 2'd0;
  assign wr_alm  = req && wr  && addr[3:2] == 2'd1;
  assign rd_sts  = req && !wr && addr[3:2] == 2'd3;
  assign restart = wr_ctl && wdata[RST_BIT];

  assign tick      = !restart && presc_q != '0 && div_q >= presc_q - 1'b1;
  assign count_inc = count_q + 1'b1;
  assign hit       = tick && count_inc == alarm_q && alarm_q != '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      en_q    <= '0;
      alarm_q <= '1;
    end else begin
      if (wr_ctl) begin
        presc_q <= wdata[PRESC_W-1:0];
        en_q    <= {wdata[EN_INC], wdata[EN_ALM]};
      end
      if (wr_alm) alarm_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      count_q <= '0;
    end else if (restart) begin
      div_q   <= '0;
      count_q <= '0;
    end else if (tick) begin
      div_q   <= '0;
      count_q <= count_inc;
    end else if (presc_q != '0) begin
      div_q   <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= {tick, hit} | (sts_q & {2{!rd_sts}});
  end

  always_comb begin
    case (addr[3:2])
      2'd0:    rdata = {{(DW-PRESC_W-2){1'b0}}, en_q[1], en_q[0], presc_q};
      2'd1:    rdata = alarm_q;
      2'd2:    rdata = count_q;
      default: rdata = {{(DW-2){1'b0}}, sts_q};
    endcase
  end

  assign irq = |(sts_q & en_q);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q != $past(count_q) |-> (count_q == $past(count_q) + 1'b1 || count_q == '0));
  assert_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_q == '0 && !restart) |=> $stable(count_q));
  assert_restart_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count_q == '0 && div_q == '0));
  assert_tick_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> sts_q[1]);
  assert_alarm_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> sts_q[0]);
  assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sts && !tick && !hit) |=> sts_q == 2'b00);
  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> sts_q != 2'b00);
endmodule

// File: tb/rt_sec_timer_test.sv
module rt_sec_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [3:0] A_CTL = 4'h0, A_ALM = 4'h4, A_CNT = 4'h8, A_STS = 4'hC;

  rt_sec_timer uut (.clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
                    .wdata(wdata), .rdata(rdata), .irq(irq));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 5000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always begin
    @(negedge clk);
    #3;
    if (req && !wr && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks = checks + 1;
      if (rdata !== e) begin
        errors = errors + 1;
        $display("FAIL %s: addr %h actual %h expected %h", t, addr, rdata, e);
      end
    end
  end

  task automatic do_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = a; wdata = d;
  endtask

  task automatic do_read(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    req = 1'b1; wr = 1'b0; addr = a; wdata = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
    #3;
    checks = checks + 1;
    if (irq !== e) begin
      errors = errors + 1;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req = 1'b0; wr = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(1'b0, "R1 irq");
    do_read(A_CTL, 32'h0, "R1 control");
    do_read(A_ALM, 32'hFFFF_FFFF, "R1 alarm");
    do_read(A_CNT, 32'h0, "R1 count");
    do_read(A_STS, 32'h0, "R1 events");

    // R3 divide by 4 from a restart (R5)
    do_write(A_CTL, 32'h0004_0004);
    for (int i = 1; i <= 9; i++) do_read(A_CNT, 32'((i - 1) / 4), "R3 count");

    // R5 restart clears count, restart bit reads 0 (R2 readback)
    do_write(A_CTL, 32'h0004_0004);
    do_read(A_CTL, 32'h0000_0004, "R5 R2 control readback");
    do_read(A_CNT, 32'h0, "R5 count cleared");
    do_write(A_CTL, 32'h0);
    do_read(A_CNT, 32'h0, "R4 stopped");
    idle(10);
    do_read(A_CNT, 32'h0, "R4 still stopped");

    // R6 writes to count and events ignored; R7 flag from earlier advances; R11 masked
    do_write(A_CNT, 32'hFFFF_FFFF);
    do_write(A_STS, 32'h0);
    do_read(A_CNT, 32'h0, "R6 count unchanged");
    chk_irq(1'b0, "R11 masked");
    do_read(A_STS, 32'h2, "R6 R7 events");
    do_read(A_STS, 32'h0, "R9 cleared");

    // R8 alarm at 3, divide 1, alarm enable
    do_write(A_ALM, 32'h3);
    do_read(A_ALM, 32'h3, "R2 alarm readback");
    do_write(A_CTL, 32'h0005_0001);
    chk_irq(1'b0, "R8 before match 0");
    chk_irq(1'b0, "R8 before match 1");
    chk_irq(1'b0, "R8 before match 2");
    chk_irq(1'b1, "R8 R11 alarm irq");
    do_read(A_STS, 32'h3, "R8 events");
    do_read(A_STS, 32'h2, "R10 advance survives read");
    do_write(A_CTL, 32'h0001_0000);
    do_read(A_CNT, 32'h7, "R4 held after stop");
    do_read(A_STS, 32'h2, "R9 events");
    chk_irq(1'b0, "R11 no source");
    do_read(A_STS, 32'h0, "R9 cleared again");
    idle(5);
    do_read(A_CNT, 32'h7, "R4 still held");

    // R11 advance interrupt, divide 2
    do_write(A_CTL, 32'h0006_0002);
    chk_irq(1'b0, "R11 pre tick 0");
    chk_irq(1'b0, "R11 pre tick 1");
    chk_irq(1'b1, "R11 R7 advance irq");
    do_read(A_CNT, 32'h1, "R3 divide 2 count");

    idle(2);
    done = 1'b1;
    if (exp_q.size() != 0) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule